// File: doc/BRIEF.md
# Watchdog Timer with Reset Control

This block is an 8-bit up-counter that acts either as a watchdog or as a periodic interval timer, reached through a small byte-wide register bus. Software picks the mode and starts the timer through a control register. It then refreshes the count through the counter register, before the count wraps. A count-enable strobe from outside sets the tick rate.

In watchdog mode a wrap from 0xFF to 0x00 sets a sticky overflow flag and stops the timer. If the reset-enable bit is set, the wrap also drives a fixed-length internal reset pulse. The flag sits in a reset control/status register. Only the pin reset and the deep-standby reset initialise that register. The block's own reset pulse does not touch it, so software can read the flag afterwards to find why the chip restarted. To clear the flag, software must first read it as 1 and then write it with 0. In interval mode a wrap raises a one-cycle interrupt and the count runs on.

Top module: `wdt_rstctl`

## Requirements
- R1: After either reset input is asserted and then released, the control register (address 0) reads 0x00, the counter (address 1) reads 0x00, the status register (address 2) reads 0x1F, and both wdt_rst_o and ivl_irq_o are low.
- R2: The counter goes up by exactly one in each cycle in which cnt_tick is high and the run bit (control bit 0) is 1. In any other cycle it holds its value.
- R3: A wrap from 0xFF to 0x00 while the mode bit (control bit 1) is 1 sets status bit 7. A wrap while the mode bit is 0 leaves bit 7 unchanged.
- R4: A write of 0 to status bit 7 clears it only if the previous status-register access was a read that returned bit 7 as 1. A write of 0 with no such read, or a write of 1, leaves the flag set.
- R5: With status bit 6 set to 1, a watchdog-mode wrap drives wdt_rst_o high for exactly 4 cycles, starting in the cycle after the wrap. With bit 6 at 0, wdt_rst_o stays low.
- R6: A watchdog-mode wrap clears the control register and leaves the counter at 0x00, whatever the value of status bit 6.
- R7: The internal reset pulse leaves the status register unchanged. After the pulse, bits 7, 6 and 5 keep their values.
- R8: Status bit 5 stores the value written to it and has no effect on operation. Bits 4 to 0 always read 1, whatever is written to them.
- R9: In interval mode each wrap drives ivl_irq_o high for the single cycle after the wrap. The control register keeps its value and wdt_rst_o stays low.
- R10: If a watchdog-mode wrap happens in the same cycle as a write that would clear the flag after a valid read, the flag stays 1.
- R11: A bus write to the counter in a cycle that would also increment it loads the written value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pin_rst_n | input | 1 | External pin reset, active low, asynchronous assertion |
| dstby_rst_n | input | 1 | Deep-standby reset, active low, asynchronous assertion |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe (qualified by bus_sel) |
| bus_rd | input | 1 | Read strobe (qualified by bus_sel) |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| cnt_tick | input | 1 | Count-enable strobe |
| wdt_rst_o | output | 1 | Internal reset pulse |
| ivl_irq_o | output | 1 | Interval-mode interrupt pulse |

## Verification
The counter is driven through runs of ticks below the wrap, through a preloaded wrap in interval mode, and through watchdog wraps with the reset enable both off and on. Comparing these runs separates the flag-setting path from the interrupt path and the reset-pulse path. The flag-clearing protocol is tried with an unarmed write of 0, an armed write of 1 and an armed write of 0, which tells the arming latch apart from a plain write-to-clear. Two cases place events in the same cycle: a counter write together with a tick, and an armed clear together with a wrap. These show which side wins each collision. Bit 5 is set before the deep-standby reset is pulsed, so the bench can show that this second reset input also restores 0x1F.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_W = 8;
  localparam int ADR_W = 2;

  localparam logic [ADR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADR_W-1:0] ADR_CNT  = 2'd1;
  localparam logic [ADR_W-1:0] ADR_RCS  = 2'd2;

  // control register bit positions
  localparam int CTRL_RUN = 0;
  localparam int CTRL_WDM = 1;

  // reset control/status register bit positions
  localparam int RCS_FLAG  = 7;
  localparam int RCS_RSTEN = 6;
  localparam int RCS_SPARE = 5;
  localparam logic [4:0] RCS_ONES = 5'h1F;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run,
  input  logic             wd_mode,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_wd,
  output logic             wrap_ivl
);
  logic             inc;
  logic             wrap;
  logic [CNT_W-1:0] cnt_d;

  assign inc      = run & tick;
  assign wrap     = inc & (&cnt_q) & ~ld;
  assign wrap_wd  = wrap & wd_mode;
  assign wrap_ivl = wrap & ~wd_mode;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)       cnt_d = ld_val;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_rcs.sv
module wdt_rcs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [BUS_W-1:0] wdata,
  input  logic             set_ovf,
  output logic [BUS_W-1:0] value,
  output logic             flag,
  output logic             rst_en
);
  logic flag_d, arm_q, arm_d, en_d, spare_q, spare_d;

  always_comb begin
    arm_d = arm_q;
    if (wr)             arm_d = 1'b0;
    else if (rd && flag) arm_d = 1'b1;

    flag_d = flag;
    if (set_ovf)                           flag_d = 1'b1;
    else if (wr && arm_q && !wdata[RCS_FLAG]) flag_d = 1'b0;

    en_d    = wr ? wdata[RCS_RSTEN] : rst_en;
    spare_d = wr ? wdata[RCS_SPARE] : spare_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flag    <= 1'b0;
      arm_q   <= 1'b0;
      rst_en  <= 1'b0;
      spare_q <= 1'b0;
    end else begin
      flag    <= flag_d;
      arm_q   <= arm_d;
      rst_en  <= en_d;
      spare_q <= spare_d;
    end
  end

  assign value = {flag, rst_en, spare_q, RCS_ONES};
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOADV = CW'(LEN);

  logic [CW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (trig)             left_d = LOADV;
    else if (left_q != '0) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) left_q <= '0;
    else         left_q <= left_d;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl
  import wdt_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int RST_PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             pin_rst_n,
  input  logic             dstby_rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             cnt_tick,
  output logic             wdt_rst_o,
  output logic             ivl_irq_o
);
  // reset: asserted asynchronously, released through a synchronizer
  logic                   rst_any_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   arst_n;

  assign rst_any_n = pin_rst_n & dstby_rst_n;

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign arst_n = sync_q[SYNC_STAGES-1];

  // bus decode
  logic ctrl_wr, cnt_wr, rcs_wr, rcs_rd;
  assign ctrl_wr = bus_sel & bus_wr & (bus_addr == ADR_CTRL);
  assign cnt_wr  = bus_sel & bus_wr & (bus_addr == ADR_CNT);
  assign rcs_wr  = bus_sel & bus_wr & (bus_addr == ADR_RCS);
  assign rcs_rd  = bus_sel & bus_rd & (bus_addr == ADR_RCS);

  // control register
  logic run_q, run_d, wdm_q, wdm_d;
  logic wrap_wd, wrap_ivl;

  always_comb begin
    run_d = run_q;
    wdm_d = wdm_q;
    if (wrap_wd) begin
      run_d = 1'b0;
      wdm_d = 1'b0;
    end else if (ctrl_wr) begin
      run_d = bus_wdata[CTRL_RUN];
      wdm_d = bus_wdata[CTRL_WDM];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q <= 1'b0;
      wdm_q <= 1'b0;
    end else begin
      run_q <= run_d;
      wdm_q <= wdm_d;
    end
  end

  // counter
  logic [CNT_W-1:0] cnt_q;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .arst_n   (arst_n),
    .run      (run_q),
    .wd_mode  (wdm_q),
    .tick     (cnt_tick),
    .ld       (cnt_wr),
    .ld_val   (bus_wdata[CNT_W-1:0]),
    .cnt_q    (cnt_q),
    .wrap_wd  (wrap_wd),
    .wrap_ivl (wrap_ivl)
  );

  // reset control/status register
  logic [BUS_W-1:0] rcs_val;
  logic             rcs_flag, rst_en;

  wdt_rcs u_rcs (
    .clk     (clk),
    .arst_n  (arst_n),
    .wr      (rcs_wr),
    .rd      (rcs_rd),
    .wdata   (bus_wdata),
    .set_ovf (wrap_wd),
    .value   (rcs_val),
    .flag    (rcs_flag),
    .rst_en  (rst_en)
  );

  // internal reset pulse
  wdt_pulse #(.LEN(RST_PULSE_LEN)) u_pulse (
    .clk    (clk),
    .arst_n (arst_n),
    .trig   (wrap_wd & rst_en),
    .pulse  (wdt_rst_o)
  );

  // interval interrupt
  logic irq_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) irq_q <= 1'b0;
    else         irq_q <= wrap_ivl;
  end
  assign ivl_irq_o = irq_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      case (bus_addr)
        ADR_CTRL: bus_rdata = {{(BUS_W-2){1'b0}}, wdm_q, run_q};
        ADR_CNT:  bus_rdata = BUS_W'(cnt_q);
        ADR_RCS:  bus_rdata = rcs_val;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_rstctl_chk.sv
module wdt_rstctl_chk #(
  parameter int CNT_W = 8,
  parameter int LEN   = 4
) (
  input logic             clk,
  input logic             arst_n,
  input logic             wrap_wd,
  input logic             rst_en,
  input logic             flag,
  input logic             rcs_wr,
  input logic             run,
  input logic             cnt_ld,
  input logic [CNT_W-1:0] ld_val,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wdt_rst,
  input logic             irq
);
  localparam int HW = $clog2(LEN + 2) + 1;
  logic [HW-1:0] hi_len;
  logic          rst_prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hi_len   <= '0;
      rst_prev <= 1'b0;
    end else begin
      rst_prev <= wdt_rst;
      if (wdt_rst) hi_len <= rst_prev ? hi_len + 1'b1 : HW'(1);
    end
  end

  p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (!arst_n)
    wrap_wd |=> flag);
  p_no_spurious_flag_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (!flag && !wrap_wd) |=> !flag);
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (flag && !rcs_wr) |=> flag);
  p_rst_len_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_prev && !wdt_rst) |-> (hi_len == HW'(LEN)));
  p_rst_gated_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (wrap_wd && !rst_en && !wdt_rst) |=> !wdt_rst);
  p_ovf_stops_r6: assert property (@(posedge clk) disable iff (!arst_n)
    wrap_wd |=> !run);
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!arst_n)
    irq |=> !irq);
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_ld |=> (cnt_q == $past(ld_val)));
endmodule

bind wdt_rstctl wdt_rstctl_chk #(.CNT_W(CNT_W), .LEN(RST_PULSE_LEN)) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .wrap_wd (wrap_wd),
  .rst_en  (rst_en),
  .flag    (rcs_flag),
  .rcs_wr  (rcs_wr),
  .run     (run_q),
  .cnt_ld  (cnt_wr),
  .ld_val  (bus_wdata[CNT_W-1:0]),
  .cnt_q   (cnt_q),
  .wdt_rst (wdt_rst_o),
  .irq     (ivl_irq_o)
);

// File: tb/sim_wdt_rstctl.sv
module sim_wdt_rstctl;
  logic       clk = 1'b0;
  logic       pin_rst_n = 1'b0;
  logic       dstby_rst_n = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cnt_tick = 1'b0;
  logic       wdt_rst_o, ivl_irq_o;

  logic       obs_req = 1'b0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int         kind;   // 0 read data, 1 reset pulse, 2 interrupt
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  wdt_rstctl u0 (
    .clk         (clk),
    .pin_rst_n   (pin_rst_n),
    .dstby_rst_n (dstby_rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cnt_tick    (cnt_tick),
    .wdt_rst_o   (wdt_rst_o),
    .ivl_irq_o   (ivl_irq_o)
  );

  // monitor: pops one expected item per observation cycle
  always @(negedge clk) begin
    if (obs_req) begin
      logic [7:0] act;
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: actual=none expected=item");
      end else begin
        it = sb.pop_front();
        case (it.kind)
          1:       act = {7'd0, wdt_rst_o};
          2:       act = {7'd0, ivl_irq_o};
          default: act = bus_rdata;
        endcase
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step(input logic s, input logic w, input logic r,
                      input logic [1:0] a, input logic [7:0] d,
                      input logic t, input logic o);
    @(posedge clk); #1;
    bus_sel = s; bus_wr = w; bus_rd = r; bus_addr = a;
    bus_wdata = d; cnt_tick = t; obs_req = o;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    step(1, 1, 0, a, d, 0, 0);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    step(1, 0, 1, a, 8'h00, 0, 1);
  endtask

  task automatic out_chk(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.exp = {7'd0, e}; it.tag = tag;
    sb.push_back(it);
    step(0, 0, 0, 2'd0, 8'h00, 0, 1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 8'h00, 1, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all R): actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 pin_rst_n = 1'b1;
    idle(4);

    // R1 reset values
    rd_chk(2'd0, 8'h00, "R1 ctrl after pin reset");
    rd_chk(2'd1, 8'h00, "R1 counter after pin reset");
    rd_chk(2'd2, 8'h1F, "R1 status after pin reset");
    out_chk(1, 1'b0, "R1 reset output low");
    out_chk(2, 1'b0, "R1 irq output low");

    // R8 spare bit stores, low bits fixed
    wr_reg(2'd2, 8'h20);
    rd_chk(2'd2, 8'h3F, "R8 spare bit set");
    wr_reg(2'd2, 8'h00);
    rd_chk(2'd2, 8'h1F, "R8 spare cleared, low ones kept");

    // R2 counting, gated by tick
    wr_reg(2'd0, 8'h01);
    wr_reg(2'd1, 8'h20);
    ticks(3);
    idle(2);
    rd_chk(2'd1, 8'h23, "R2 three ticks");

    // R11 load beats increment
    step(1, 1, 0, 2'd1, 8'h10, 1, 0);
    rd_chk(2'd1, 8'h10, "R11 load over tick");

    // R9 interval wrap
    wr_reg(2'd1, 8'hFE);
    ticks(2);
    out_chk(2, 1'b1, "R9 irq after wrap");
    out_chk(2, 1'b0, "R9 irq single cycle");
    out_chk(1, 1'b0, "R9 no reset in interval mode");
    rd_chk(2'd0, 8'h01, "R9 ctrl kept");
    rd_chk(2'd1, 8'h00, "R9 counter wrapped");
    rd_chk(2'd2, 8'h1F, "R3 no flag in interval mode");

    // R6 watchdog wrap with reset disabled
    wr_reg(2'd0, 8'h03);
    wr_reg(2'd1, 8'hFE);
    ticks(2);
    out_chk(1, 1'b0, "R5 no pulse when disabled");
    rd_chk(2'd0, 8'h00, "R6 ctrl cleared, reset off");
    rd_chk(2'd1, 8'h00, "R6 counter zero");

    // R4 clearing protocol
    wr_reg(2'd2, 8'h00);
    rd_chk(2'd2, 8'h9F, "R3 flag set; R4 unarmed write kept it");
    wr_reg(2'd2, 8'h80);
    rd_chk(2'd2, 8'h9F, "R4 write of one no effect");
    wr_reg(2'd2, 8'h00);
    rd_chk(2'd2, 8'h1F, "R4 armed write of zero clears");

    // R5 reset pulse with enable
    wr_reg(2'd2, 8'h40);
    wr_reg(2'd0, 8'h03);
    wr_reg(2'd1, 8'hFE);
    ticks(2);
    out_chk(1, 1'b1, "R5 pulse cycle 1");
    out_chk(1, 1'b1, "R5 pulse cycle 2");
    out_chk(1, 1'b1, "R5 pulse cycle 3");
    out_chk(1, 1'b1, "R5 pulse cycle 4");
    out_chk(1, 1'b0, "R5 pulse ended");
    rd_chk(2'd2, 8'hDF, "R7 status survives pulse");
    rd_chk(2'd0, 8'h00, "R6 ctrl cleared, reset on");

    // R10 set beats armed clear (armed by the read above)
    wr_reg(2'd0, 8'h03);
    wr_reg(2'd1, 8'hFF);
    step(1, 1, 0, 2'd2, 8'h40, 1, 0);
    idle(6);
    rd_chk(2'd2, 8'hDF, "R10 flag kept on collision");
    wr_reg(2'd2, 8'h00);
    rd_chk(2'd2, 8'h1F, "R4 clear after collision");

    // R1 deep-standby reset
    wr_reg(2'd2, 8'h60);
    wr_reg(2'd0, 8'h01);
    rd_chk(2'd2, 8'h7F, "R8 bits 6 and 5 set");
    idle(1);
    @(posedge clk); #1 dstby_rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 dstby_rst_n = 1'b1;
    idle(4);
    rd_chk(2'd2, 8'h1F, "R1 status after standby reset");
    rd_chk(2'd0, 8'h00, "R1 ctrl after standby reset");
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule